// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block compares every data access against a small bank of programmed watchpoint slots. When an access hits one of them, it raises a hit flag with a slot number. Each slot holds a 32-bit control word and a base address. The control word turns the slot on and sets which access directions and which privilege levels count. It also chooses how the address is compared. In byte-select mode, a byte mask picks bytes inside one aligned 8-byte doubleword. In range mode, a mask count ignores low address bits, so the slot covers a naturally aligned power-of-two region.

Software, or a debug agent, writes slots through a plain single-cycle write port. The access side presents an address, a size code, the direction and the privilege on a strobe. One cycle later the block reports whether any slot matched and gives the lowest-numbered matching slot. A trap unit can then act on that result.

Top module: `watch_match`

## Requirements
- R1: After reset every control word is zero. Every slot is disabled, hitValid and hitIdx read 0, and no access hits.
- R2: A slot whose control bit 0 (enable) is 0 never hits.
- R3: Control bits [4:3] filter on access direction. 01 matches loads only (accStore=0), 10 matches stores only (accStore=1), 11 matches both, and 00 matches nothing.
- R4: Control bits [2:1] filter on privilege. 01 matches kernel accesses only (accKernel=1), 10 matches user accesses only, 11 matches both, and 00 matches nothing.
- R5: With mask count 0, a slot hits when the access address and the slot base agree above bit 2 and the access touches at least one byte whose bit is set in the byte-select field, control bits [12:5]. Bit k of that field selects byte k of the doubleword. The access size code accSize gives 1, 2, 4 or 8 bytes for 0, 1, 2 or 3. The low 3 bits of the base are ignored.
- R6: In byte-select mode, any access bytes that lie past the end of the access's own doubleword are not compared. A region that crosses a doubleword boundary is therefore matched only in the doubleword where the access starts.
- R7: With a mask count m of 3 or more in control bits [28:24], the slot hits when the access address and the base agree in all bits from m upward. This also needs the byte-select field to be 0xFF; with any other value the slot never hits.
- R8: A slot with mask count 1 or 2 never hits.
- R9: When several slots hit, hitIdx reports the lowest-numbered one.
- R10: hitValid and hitIdx are registered. They show the result of the access presented in the previous cycle, and read 0 in a cycle that follows no access. A write to a slot takes effect for accesses from the next cycle, so an access in the same cycle as the write sees the old contents.
- R11: One write changes exactly one register of the slot wrIdx: the control word when wrSel=0, the base address when wrSel=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the programming port |
| wrSel | input | 1 | 0 selects the control word, 1 selects the base address |
| wrIdx | input | IDX_W | Slot number to write |
| wrData | input | ADDR_W | Write data; the control word uses bits [31:0] |
| accValid | input | 1 | Access strobe |
| accAddr | input | ADDR_W | Byte address of the access |
| accSize | input | 2 | Size code: log2 of the access length in bytes |
| accStore | input | 1 | 1 for a store, 0 for a load |
| accKernel | input | 1 | 1 for a kernel access, 0 for a user access |
| hitValid | output | 1 | The previous cycle's access hit a slot |
| hitIdx | output | IDX_W | Lowest-numbered hitting slot, 0 when there is no hit |

## Verification
The assertions check several things on every cycle. A slot that is disabled, has direction code 00, has privilege code 00, or has a reserved mask count never raises its comparator. No hit appears without an access in the cycle before it. Slot 0 always wins when it matches. The programming decode never selects more than one slot.

Other behaviour only shows up in the bench's scenarios, which compare results against a behavioural model of the slots:
- which bytes a given address and size actually touch
- how an access that runs past the end of its doubleword is cut off
- the boundaries of a power-of-two region
- which slot wins when a higher-numbered slot also hits
- that an access in the same cycle as a write sees the old contents

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  // control word field positions, decoded by the comparators
  localparam int EnBit     = 0;
  localparam int PrivLo    = 1;
  localparam int KindLo    = 3;
  localparam int BasLo     = 5;
  localparam int BasW      = 8;
  localparam int MaskLo    = 24;
  localparam int MaskW     = 5;
  localparam int CtrlW     = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrValue;
    logic lookup;
  } wpmStrobe_t;
endpackage

// File: rtl/wpm_ctrl.sv
module wpm_ctrl
  import wpm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 accValid,
  output wpmStrobe_t           stb,
  output logic [NUM_SLOTS-1:0] slotSel
);
  logic idxOk;

  assign idxOk = (int'(wrIdx) < NUM_SLOTS);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSel
    assign slotSel[g] = wrEn && (int'(wrIdx) == g);
  end

  always_comb begin
    stb.wrCtrl  = wrEn && !wrSel && idxOk;
    stb.wrValue = wrEn &&  wrSel && idxOk;
    stb.lookup  = accValid;
  end

  // R11: a write never selects more than one slot
  a_r11_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slotSel));
endmodule

// File: rtl/wpm_datapath.sv
module wpm_datapath
  import wpm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wpmStrobe_t           stb,
  input  logic [NUM_SLOTS-1:0] slotSel,
  input  logic [ADDR_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [1:0]           accSize,
  input  logic                 accStore,
  input  logic                 accKernel,
  output logic                 hitValid,
  output logic [IDX_W-1:0]     hitIdx
);
  logic [NUM_SLOTS-1:0] slotHit;
  logic [3:0]           nBytes;
  logic [8:0]           lenMask;
  logic [7:0]           touched;
  logic                 anyHit;
  logic [IDX_W-1:0]     winIdx;

  // bytes of the access doubleword touched; bytes past byte 7 fall off
  assign nBytes  = 4'd1 << accSize;
  assign lenMask = (9'd1 << nBytes) - 9'd1;
  assign touched = lenMask[7:0] << accAddr[2:0];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [CtrlW-1:0]  ctrlQ;
    logic [ADDR_W-1:0] valQ;
    logic [1:0]        kind;
    logic [1:0]        priv;
    logic [BasW-1:0]   bas;
    logic [MaskW-1:0]  maskCnt;
    logic [ADDR_W-1:0] regionMask;
    logic              kindOk;
    logic              privOk;
    logic              reserved;
    logic              dwHit;
    logic              rangeHit;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrlQ <= '0;
        valQ  <= '0;
      end else begin
        if (stb.wrCtrl && slotSel[g])  ctrlQ <= wrData[CtrlW-1:0];
        if (stb.wrValue && slotSel[g]) valQ  <= wrData;
      end
    end

    assign kind       = ctrlQ[KindLo +: 2];
    assign priv       = ctrlQ[PrivLo +: 2];
    assign bas        = ctrlQ[BasLo +: BasW];
    assign maskCnt    = ctrlQ[MaskLo +: MaskW];
    assign regionMask = {ADDR_W{1'b1}} << maskCnt;
    assign kindOk     = accStore ? kind[1] : kind[0];
    assign privOk     = accKernel ? priv[0] : priv[1];
    assign reserved   = (maskCnt == MaskW'(1)) || (maskCnt == MaskW'(2));
    assign dwHit      = (accAddr[ADDR_W-1:3] == valQ[ADDR_W-1:3]) && |(bas & touched);
    assign rangeHit   = (((accAddr ^ valQ) & regionMask) == '0) && (bas == '1);
    assign slotHit[g] = ctrlQ[EnBit] && kindOk && privOk && !reserved &&
                        ((maskCnt == '0) ? dwHit : rangeHit);

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      !ctrlQ[EnBit] |-> !slotHit[g]);
    a_r3_kind_none: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b00) |-> !slotHit[g]);
    a_r4_priv_none: assert property (@(posedge clk) disable iff (rst)
      (priv == 2'b00) |-> !slotHit[g]);
    a_r8_reserved_mask: assert property (@(posedge clk) disable iff (rst)
      ((maskCnt == MaskW'(1)) || (maskCnt == MaskW'(2))) |-> !slotHit[g]);
  end

  // lowest numbered hitting slot wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slotHit[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitValid <= 1'b0;
      hitIdx   <= '0;
    end else begin
      hitValid <= stb.lookup && anyHit;
      hitIdx   <= (stb.lookup && anyHit) ? winIdx : '0;
    end
  end

  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !stb.lookup |=> !hitValid);
  a_r10_hit_follows: assert property (@(posedge clk) disable iff (rst)
    (stb.lookup && slotHit != '0) |=> hitValid);
  a_r9_slot0_wins: assert property (@(posedge clk) disable iff (rst)
    (stb.lookup && slotHit[0]) |=> (hitIdx == '0));
endmodule

// File: rtl/watch_match.sv
module watch_match
  import wpm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accStore,
  input  logic              accKernel,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIdx
);
  wpmStrobe_t           stb;
  logic [NUM_SLOTS-1:0] slotSel;

  wpm_ctrl #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .accValid(accValid), .stb(stb), .slotSel(slotSel)
  );

  wpm_datapath #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .slotSel(slotSel), .wrData(wrData),
    .accAddr(accAddr), .accSize(accSize), .accStore(accStore),
    .accKernel(accKernel), .hitValid(hitValid), .hitIdx(hitIdx)
  );
endmodule

// File: tb/test_watch_match.sv
module test_watch_match;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        accStore = 1'b0, accKernel = 1'b1;
  logic        hitValid;
  logic [1:0]  hitIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  watch_match #(.NUM_SLOTS(NS), .ADDR_W(32)) i_watch_match (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accStore(accStore), .accKernel(accKernel),
    .hitValid(hitValid), .hitIdx(hitIdx)
  );

  // behavioural reference model
  logic [31:0] mCtrl [NS];
  logic [31:0] mVal  [NS];
  bit          expV;
  int          expI;

  function automatic bit refHit(int i);
    logic [31:0] c = mCtrl[i];
    int msk = int'(c[28:24]);
    logic [7:0] bas = c[12:5];
    int off = int'(accAddr[2:0]);
    int nb = 1 << accSize;
    if (!c[0]) return 0;
    if (accStore ? !c[4] : !c[3]) return 0;
    if (accKernel ? !c[1] : !c[2]) return 0;
    if (msk == 1 || msk == 2) return 0;
    if (msk != 0) return (bas == 8'hFF) && ((accAddr >> msk) == (mVal[i] >> msk));
    if ((accAddr >> 3) != (mVal[i] >> 3)) return 0;
    for (int b = off; b < off + nb && b < 8; b++) if (bas[b]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin mCtrl[i] = '0; mVal[i] = '0; end
      expV = 0; expI = 0;
    end else begin
      expV = 0; expI = 0;
      if (accValid)
        for (int i = 0; i < NS; i++)
          if (!expV && refHit(i)) begin expV = 1; expI = i; end
      if (wrEn) begin
        if (wrSel) mVal[wrIdx] = wrData;
        else       mCtrl[wrIdx] = wrData;
      end
    end
  end

  // every-cycle comparison against the model (R10 timing, all functions)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (hitValid !== expV || int'(hitIdx) != expI) begin
        errors++;
        $display("FAIL R10 model compare: actual valid=%0b idx=%0d expected valid=%0b idx=%0d",
                 hitValid, hitIdx, expV, expI);
      end
    end
  end

  task automatic wr(input int idx, input bit sel, input logic [31:0] d);
    wrEn = 1; wrIdx = 2'(idx); wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input bit st,
                     input bit kr, input bit ev, input int ei, input string req);
    accValid = 1; accAddr = a; accSize = sz; accStore = st; accKernel = kr;
    @(negedge clk);
    accValid = 0;
    checks++;
    if (hitValid !== ev || (ev && int'(hitIdx) != ei)) begin
      errors++;
      $display("FAIL %s addr=%h: actual valid=%0b idx=%0d expected valid=%0b idx=%0d",
               req, a, hitValid, hitIdx, ev, ei);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (hitValid !== 1'b0 || hitIdx !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual valid=%0b idx=%0d expected 0 0", hitValid, hitIdx);
    end
    acc(32'h1000, 0, 0, 1, 0, 0, "R1");

    wr(0, 1, 32'h1005);
    wr(0, 0, 32'h1FE);
    acc(32'h1000, 0, 0, 1, 0, 0, "R2");
    wr(0, 0, 32'h1FF);

    acc(32'h1000, 0, 0, 1, 1, 0, "R5");
    acc(32'h1002, 0, 0, 1, 1, 0, "R5");
    acc(32'h1004, 0, 0, 1, 0, 0, "R5");
    acc(32'h1003, 1, 0, 1, 1, 0, "R5");
    acc(32'h1004, 3, 0, 1, 0, 0, "R5");
    acc(32'h1000, 3, 0, 1, 1, 0, "R5");
    acc(32'h1008, 0, 0, 1, 0, 0, "R5");

    wr(0, 0, 32'h1EF);
    acc(32'h1001, 0, 0, 1, 1, 0, "R3");
    acc(32'h1001, 0, 1, 1, 0, 0, "R3");
    wr(0, 0, 32'h1F7);
    acc(32'h1001, 0, 1, 1, 1, 0, "R3");
    acc(32'h1001, 0, 0, 1, 0, 0, "R3");
    wr(0, 0, 32'h1E7);
    acc(32'h1001, 0, 0, 1, 0, 0, "R3");
    acc(32'h1001, 0, 1, 1, 0, 0, "R3");

    wr(0, 0, 32'h1FB);
    acc(32'h1001, 0, 0, 1, 1, 0, "R4");
    acc(32'h1001, 0, 0, 0, 0, 0, "R4");
    wr(0, 0, 32'h1FD);
    acc(32'h1001, 0, 0, 0, 1, 0, "R4");
    acc(32'h1001, 0, 0, 1, 0, 0, "R4");
    wr(0, 0, 32'h1F9);
    acc(32'h1001, 0, 0, 1, 0, 0, "R4");
    acc(32'h1001, 0, 0, 0, 0, 0, "R4");

    wr(0, 0, 32'h181F);
    wr(1, 1, 32'h1008);
    wr(1, 0, 32'h3F);
    acc(32'h1006, 2, 0, 1, 1, 0, "R6");
    wr(0, 0, 32'h0);
    acc(32'h1006, 2, 0, 1, 0, 0, "R6");
    acc(32'h1008, 0, 0, 1, 1, 1, "R11");
    acc(32'h100F, 0, 0, 1, 0, 0, "R5");

    wr(2, 1, 32'h5123);
    wr(2, 0, 32'h0C001FFF);
    acc(32'h5FFC, 2, 0, 1, 1, 2, "R7");
    acc(32'h5000, 3, 0, 1, 1, 2, "R7");
    acc(32'h6000, 0, 0, 1, 0, 0, "R7");
    acc(32'h4FFF, 0, 0, 1, 0, 0, "R7");
    wr(2, 0, 32'h0C001FDF);
    acc(32'h5000, 0, 0, 1, 0, 0, "R7");

    wr(2, 0, 32'h01001FFF);
    acc(32'h5123, 0, 0, 1, 0, 0, "R8");
    wr(2, 0, 32'h02001FFF);
    acc(32'h5123, 0, 0, 1, 0, 0, "R8");

    wr(2, 0, 32'h0);
    wr(1, 1, 32'h2000);
    wr(1, 0, 32'h1FF);
    wr(3, 1, 32'h2000);
    wr(3, 0, 32'h1FF);
    acc(32'h2001, 0, 0, 1, 1, 1, "R9");
    wr(1, 0, 32'h0);
    acc(32'h2001, 0, 0, 1, 1, 3, "R9");

    // R10: idle cycle after an access reads 0
    @(negedge clk);
    checks++;
    if (hitValid !== 1'b0 || hitIdx !== 2'd0) begin
      errors++;
      $display("FAIL R10 idle: actual valid=%0b idx=%0d expected 0 0", hitValid, hitIdx);
    end
    // R10: write and access in the same cycle, access sees old contents
    wrEn = 1; wrIdx = 2'd3; wrSel = 0; wrData = 32'h0;
    acc(32'h2001, 0, 0, 1, 1, 3, "R10");
    wrEn = 0;
    acc(32'h2001, 0, 0, 1, 0, 0, "R10");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule